// File: doc/BRIEF.md
# VBUS Droop Masking Filter

This block sits between the synchronised supply comparators and the session logic of a USB host or OTG A-device controller. It decides what the controller believes about the VBUS supply. When a device is plugged in, its in-rush current can pull VBUS briefly under the 4.75 V valid level. Without filtering, the controller would read that dip as a supply fault, switch the port power off and enumerate the device again. The filter hides such a dip for a fixed time, provided the supply stays at or above the 2.0 V A-valid level.

Masking is gated by two inputs: a software enable bit and a host-mode indication. The enable bit sits at position 0 of a 32-bit control word whose upper bits are reserved and read as zero. The register decode that holds this word lives outside the block. While masking is gated off, the filtered status tracks the raw comparator and any loss raises the error pulse. While masking is gated on, a fall between the two thresholds starts a window of ceil(65 µs × clock frequency) cycles. During that window the filtered status stays valid. If the supply recovers in time, nothing is reported. If it does not, the status drops at the end of the window and one error pulse is issued. A drop below A-valid is never masked.

Top module: `vbus_droop_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, the filtered status, the error pulse and the masking flag are all 0.
- R2: With the enable or the host-mode input low, a fall of raw VBUS-valid (A-valid still high) drives the filtered status to 0 in the next cycle. It also gives exactly one error pulse of one cycle.
- R3: With masking gated on, a fall of raw VBUS-valid while A-valid stays high raises the masking flag from the next cycle on. The filtered status stays 1 for at most WIN cycles, where WIN = ceil(65 µs × CLK_HZ), which is 16250 at the default 250 MHz.
- R4: If raw VBUS-valid returns while the masking flag is high, including in the last window cycle, the next cycle shows masking 0 and filtered status 1, with no error pulse. A later droop again gets the full WIN cycles.
- R5: If raw VBUS-valid is still low after WIN masking cycles, the filtered status falls to 0 in the following cycle, together with exactly one error pulse.
- R6: A low A-valid while the filtered status is 1 (masking or not) gives filtered status 0 and an error pulse in the next cycle.
- R7: While the filtered status is 0 and raw VBUS-valid stays low, no masking starts and no further error pulse is issued.
- R8: A low host-mode input behaves like a 0 enable bit. Dropping either one during a window ends masking in the next cycle, and if VBUS is still low, the filtered status falls and one error pulse is issued.
- R9: The error pulse never lasts more than one cycle, and every fall of the filtered status comes with one.
- R10: From the invalid state, the filtered status returns to 1 one cycle after raw VBUS-valid and A-valid are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| droop_mask_en | input | 1 | Enable bit (bit 0 of the control word) |
| host_mode | input | 1 | High when the controller acts as host or A-device |
| vbus_hi_raw | input | 1 | Synchronised VBUS-valid comparator (4.75 V) |
| vbus_lo_raw | input | 1 | Synchronised A-valid comparator (2.0 V) |
| vbus_ok | output | 1 | Filtered VBUS-valid status |
| vbus_err | output | 1 | One-cycle VBUS error interrupt pulse |
| mask_busy | output | 1 | High while a droop is being masked |

## Verification
A state register stuck in the masking state would keep the filtered status high past the window. The window-length check would then report it one cycle after cycle WIN. A wrong terminal count in the window counter moves the error pulse and the fall of the status earlier or later, and this shows as a mismatch in the masking-cycle count of a timeout droop. A missing or extra transition, such as re-arming from the invalid state or masking with the gate off, shows within one cycle as a masking flag where none is allowed or as a missing or double error pulse.

// File: rtl/vbus_droop_pkg.sv
`timescale 1ns/1ps
package vbus_droop_pkg;

  // Supply-tracking states of the masking controller
  typedef enum logic [1:0] {
    ST_INVALID = 2'd0,  // supply reported invalid, waiting for full recovery
    ST_GOOD    = 2'd1,  // supply reported valid and raw flag high
    ST_MASKING = 2'd2   // droop hidden, window counting
  } droop_state_e;

  // Window length in cycles, rounded up
  function automatic int unsigned window_cycles(input longint unsigned clk_hz,
                                                input longint unsigned win_ns);
    longint unsigned prod;
    prod = clk_hz * win_ns;
    return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/droop_window_timer.sv
`timescale 1ns/1ps
module droop_window_timer #(
  parameter int unsigned WIN_CYC = 16250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned CW = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign last = (cnt_q == CW'(WIN_CYC - 1));

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!run) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (!last) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/droop_mask_fsm.sv
`timescale 1ns/1ps
module droop_mask_fsm
  import vbus_droop_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  input  logic         hi_ok,
  input  logic         lo_ok,
  input  logic         win_last,
  output droop_state_e state_q,
  output logic         fault_set
);
  droop_state_e state_d;
  logic         state_en;

  always_comb begin
    state_d   = state_q;
    fault_set = 1'b0;
    case (state_q)
      ST_INVALID: begin
        if (hi_ok && lo_ok) state_d = ST_GOOD;
      end
      ST_GOOD: begin
        if (!lo_ok) begin
          state_d   = ST_INVALID;
          fault_set = 1'b1;
        end else if (!hi_ok) begin
          if (gate) begin
            state_d = ST_MASKING;
          end else begin
            state_d   = ST_INVALID;
            fault_set = 1'b1;
          end
        end
      end
      ST_MASKING: begin
        if (!lo_ok) begin
          state_d   = ST_INVALID;
          fault_set = 1'b1;
        end else if (hi_ok) begin
          state_d = ST_GOOD;
        end else if (!gate || win_last) begin
          state_d   = ST_INVALID;
          fault_set = 1'b1;
        end
      end
      default: state_d = ST_INVALID;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_INVALID;
    else if (state_en) state_q <= state_d;
  end
endmodule

// File: rtl/droop_err_pulse.sv
`timescale 1ns/1ps
module droop_err_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic pulse_en;

  assign pulse_en = fire | pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse <= 1'b0;
    else if (pulse_en) pulse <= fire;
  end
endmodule

// File: rtl/vbus_droop_filter.sv
`timescale 1ns/1ps
module vbus_droop_filter
  import vbus_droop_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned WINDOW_NS = 65_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic droop_mask_en,
  input  logic host_mode,
  input  logic vbus_hi_raw,
  input  logic vbus_lo_raw,
  output logic vbus_ok,
  output logic vbus_err,
  output logic mask_busy
);
  localparam int unsigned WIN_CYC = window_cycles(64'(CLK_HZ), 64'(WINDOW_NS));

  droop_state_e state;
  logic         gate;
  logic         win_last;
  logic         fault_set;

  assign gate = droop_mask_en & host_mode;

  droop_mask_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate     (gate),
    .hi_ok    (vbus_hi_raw),
    .lo_ok    (vbus_lo_raw),
    .win_last (win_last),
    .state_q  (state),
    .fault_set(fault_set)
  );

  droop_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state == ST_MASKING),
    .last (win_last)
  );

  droop_err_pulse u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (fault_set),
    .pulse(vbus_err)
  );

  assign vbus_ok   = (state != ST_INVALID);
  assign mask_busy = (state == ST_MASKING);
endmodule

// File: rtl/vbus_droop_filter_chk.sv
`timescale 1ns/1ps
module vbus_droop_filter_chk
  import vbus_droop_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned WINDOW_NS = 65_000
) (
  input logic clk,
  input logic rst_n,
  input logic droop_mask_en,
  input logic host_mode,
  input logic vbus_hi_raw,
  input logic vbus_lo_raw,
  input logic vbus_ok,
  input logic vbus_err,
  input logic mask_busy
);
  localparam int unsigned WIN = window_cycles(64'(CLK_HZ), 64'(WINDOW_NS));

  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= 0;
    else if (mask_busy) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_busy |-> (run_len < WIN));

  p_recover_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_busy && vbus_hi_raw && vbus_lo_raw) |=> (vbus_ok && !mask_busy && !vbus_err));

  p_low_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_ok && !vbus_lo_raw) |=> (!vbus_ok && vbus_err));

  p_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbus_ok && !vbus_hi_raw) |=> (!mask_busy && !vbus_err));

  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(droop_mask_en && host_mode) |=> !mask_busy);

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_err |=> !vbus_err);

  p_fall_has_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vbus_ok) |-> vbus_err);

  p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbus_ok && vbus_hi_raw && vbus_lo_raw) |=> vbus_ok);
endmodule

bind vbus_droop_filter vbus_droop_filter_chk #(
  .CLK_HZ   (CLK_HZ),
  .WINDOW_NS(WINDOW_NS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .droop_mask_en(droop_mask_en),
  .host_mode    (host_mode),
  .vbus_hi_raw  (vbus_hi_raw),
  .vbus_lo_raw  (vbus_lo_raw),
  .vbus_ok      (vbus_ok),
  .vbus_err     (vbus_err),
  .mask_busy    (mask_busy)
);

// File: tb/sim_vbus_droop_filter.sv
`timescale 1ns/1ps
module sim_vbus_droop_filter;
  // 65 us at 250 MHz
  localparam int WIN = 16250;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, en, host, hi, lo;
  logic ok, err, busy;

  vbus_droop_filter u0 (
    .clk(clk), .rst_n(rst_n), .droop_mask_en(en), .host_mode(host),
    .vbus_hi_raw(hi), .vbus_lo_raw(lo),
    .vbus_ok(ok), .vbus_err(err), .mask_busy(busy)
  );

  int n_chk = 0;
  int n_bad = 0;
  int errs  = 0;
  int mcyc  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (err)  errs++;
    if (busy) mcyc++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clr();
    errs = 0;
    mcyc = 0;
  endtask

  task automatic restore();
    hi = 1'b1; lo = 1'b1; host = 1'b1;
    step();
    chk("R10", "status back after recovery", int'(ok), 1);
    clr();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; host = 1'b1; hi = 1'b1; lo = 1'b1;
    steps(3);
    chk("R1", "status in reset", int'(ok), 0);
    chk("R1", "error in reset", int'(err), 0);
    chk("R1", "mask in reset", int'(busy), 0);
    rst_n = 1'b1;
    clr();
    step();
    chk("R1", "no error after reset", errs, 0);
    chk("R10", "status valid after reset", int'(ok), 1);
    clr();
  endtask

  task automatic t_no_gate();
    en = 1'b0; clr();
    hi = 1'b0;
    step();
    chk("R2", "status falls at once", int'(ok), 0);
    chk("R2", "no masking", mcyc, 0);
    chk("R2", "error raised", int'(err), 1);
    steps(6);
    chk("R2", "single error pulse", errs, 1);
    restore();
  endtask

  task automatic t_recover();
    en = 1'b1; clr();
    hi = 1'b0;
    steps(100);
    chk("R3", "masking cycles", mcyc, 100);
    chk("R3", "status held", int'(ok), 1);
    hi = 1'b1;
    step();
    chk("R4", "masking ended", int'(busy), 0);
    chk("R4", "status kept", int'(ok), 1);
    chk("R4", "no error", errs, 0);
    // recovery in the last window cycle
    clr();
    hi = 1'b0;
    steps(WIN);
    chk("R4", "still masking at last cycle", int'(busy), 1);
    hi = 1'b1;
    step();
    chk("R4", "late recovery status", int'(ok), 1);
    chk("R4", "late recovery no error", errs, 0);
    clr();
  endtask

  task automatic t_timeout();
    en = 1'b1; clr();
    hi = 1'b0;
    for (int g = 0; g < WIN + 20; g++) begin
      step();
      if (!busy) break;
    end
    chk("R5", "full window length", mcyc, WIN);
    chk("R5", "status dropped", int'(ok), 0);
    chk("R5", "error at timeout", int'(err), 1);
    step();
    chk("R9", "error one cycle", int'(err), 0);
    // stay low: no re-arm
    clr();
    steps(300);
    chk("R7", "no masking while invalid", mcyc, 0);
    chk("R7", "no extra error", errs, 0);
    chk("R7", "status stays low", int'(ok), 0);
    restore();
  endtask

  task automatic t_low_loss();
    en = 1'b1; clr();
    hi = 1'b0;
    steps(50);
    lo = 1'b0;
    step();
    chk("R6", "status on A-valid loss in window", int'(ok), 0);
    chk("R6", "error on A-valid loss", int'(err), 1);
    chk("R6", "masking ended", int'(busy), 0);
    steps(20);
    chk("R7", "single error after loss", errs, 1);
    restore();
    // both thresholds lost together from idle
    hi = 1'b0; lo = 1'b0;
    step();
    chk("R6", "status on direct loss", int'(ok), 0);
    chk("R6", "no masking on direct loss", mcyc, 0);
    chk("R6", "error on direct loss", errs, 1);
    restore();
  endtask

  task automatic t_mode();
    en = 1'b1; host = 1'b0; clr();
    hi = 1'b0;
    step();
    chk("R8", "device mode no masking", mcyc, 0);
    chk("R8", "device mode status", int'(ok), 0);
    step();
    chk("R8", "device mode one error", errs, 1);
    restore();
    hi = 1'b0;
    steps(30);
    host = 1'b0;
    step();
    chk("R8", "mask ends on mode drop", int'(busy), 0);
    chk("R8", "status on mode drop", int'(ok), 0);
    chk("R8", "masked cycles before drop", mcyc, 30);
    chk("R8", "one error on mode drop", errs, 1);
    restore();
  endtask

  initial begin
    #(4 * 180_000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_no_gate();
    t_recover();
    t_timeout();
    t_low_loss();
    t_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule